// File: doc/BRIEF.md
# Write-Masked Control Register Pair

This block keeps a 64-bit control register next to a 64-bit protection mask. A set mask bit freezes the matching control bit: any software write to the control register leaves that bit at its old value, while bits whose mask bit is clear take the written data. The control register can be reached under two names, a primary name and an alias. Both go through the same masking, so the alias gives no way around the protection.

The mask register guards itself. Once it holds a non-zero value, a rewrite from the kernel level is refused with an undefined-instruction error. The two elevated levels may still rewrite it at any time. A request from the user level is always refused. A fixed set of bit positions is reserved: those positions read as zero in both registers and take no part in masking.

Requests arrive on a single-cycle port that carries a privilege level and a target select. Any state change, read data and error pulse appears in the cycle after the request. The control and mask values are also driven out continuously so that surrounding logic can use them.

Top module: `wmcr_top`

## Requirements
- R1: After reset, `ctrl_q_o`, `mask_q_o`, `rd_data_o` and `err_o` are all zero.
- R2: An accepted control write (target 0) with a zero mask loads every non-reserved bit from `req_wdata`; `ctrl_q_o` shows it in the cycle after the request.
- R3: On an accepted control write, the new control value is (old AND mask) OR (wdata AND NOT mask), so every bit whose mask bit is 1 keeps its old value.
- R4: A write through the alias (target 1) updates the control register under exactly the same masking as target 0.
- R5: Reserved bit positions 41, 39 and 17 always read zero in `ctrl_q_o` and `mask_q_o`, whatever is written.
- R6: A mask write (target 2) at kernel level (privilege 1) while the mask is non-zero raises `err_o`, and the mask keeps its value.
- R7: A mask write at kernel level while the mask is zero is accepted, and it loads the written value with reserved bits cleared.
- R8: A mask write at privilege 2 or 3 is always accepted, whatever the mask currently holds.
- R9: Any request at user level (privilege 0), read or write, raises `err_o` and changes neither register nor `rd_data_o`.
- R10: `err_o` is high for exactly the one cycle after each rejected request, and no state changes for a rejected request. Target 3 is always rejected.
- R11: An accepted read returns the control value (targets 0 and 1) or the mask value (target 2) on `rd_data_o` in the cycle after the request. `rd_data_o` holds its value until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_target | input | 2 | 0 control, 1 control alias, 2 mask, 3 unused |
| req_priv | input | 2 | 0 user, 1 kernel, 2 and 3 elevated |
| req_wdata | input | 64 | Write data |
| rd_data_o | output | 64 | Registered read data |
| err_o | output | 1 | Undefined-instruction error pulse |
| ctrl_q_o | output | 64 | Current control register value |
| mask_q_o | output | 64 | Current mask register value |

## Verification
The bench first locks a mask with an elevated write. It then writes complementary patterns through both control names, so a design that ignored the mask on the alias would let frozen bits flip. It checks the lock boundary from both sides: a kernel write is refused when the mask is non-zero, accepted once an elevated write has cleared it, and elevated writes are never refused. A design that tested the new data instead of the current mask would fail the first of these. The bench also writes all ones into both registers to catch reserved bits that can be set. It checks that the error falls after a single cycle, and that user-level reads leave the read data untouched.

// File: rtl/wmcr_pkg.sv
package wmcr_pkg;

   typedef enum logic [1:0] {
      TGT_CTRL  = 2'd0,
      TGT_ALIAS = 2'd1,
      TGT_MASK  = 2'd2,
      TGT_NONE  = 2'd3
   } tgt_e;

   typedef enum logic [1:0] {
      PRV_USER   = 2'd0,
      PRV_KERNEL = 2'd1,
      PRV_HYP    = 2'd2,
      PRV_TOP    = 2'd3
   } prv_e;

   typedef struct packed {
      logic ctrl_we;
      logic mask_we;
      logic rd_en;
      logic rd_mask;
      logic reject;
   } dec_t;

endpackage

// File: rtl/wmcr_access_check.sv
module wmcr_access_check
   import wmcr_pkg::*;
#(
   parameter bit         ALIAS_EN = 1'b1,
   parameter logic [1:0] LOCK_PRV = 2'd1
) (
   input  logic       valid,
   input  logic       write,
   input  logic [1:0] tgt,
   input  logic [1:0] prv,
   input  logic       mask_live,
   output dec_t       dec
);

   logic is_ctrl;
   logic is_mask;
   logic tgt_ok;
   logic prv_ok;
   logic locked;
   logic accept;

   generate
      if (ALIAS_EN) begin : g_alias
         assign is_ctrl = (tgt == TGT_CTRL) || (tgt == TGT_ALIAS);
      end else begin : g_no_alias
         assign is_ctrl = (tgt == TGT_CTRL);
      end
   endgenerate

   always_comb begin
      is_mask     = (tgt == TGT_MASK);
      tgt_ok      = is_ctrl || is_mask;
      prv_ok      = (prv != PRV_USER);
      locked      = write && is_mask && (prv == LOCK_PRV) && mask_live;
      dec.reject  = valid && (!prv_ok || !tgt_ok || locked);
      accept      = valid && !dec.reject;
      dec.ctrl_we = accept && write && is_ctrl;
      dec.mask_we = accept && write && is_mask;
      dec.rd_en   = accept && !write;
      dec.rd_mask = is_mask;
   end

endmodule

// File: rtl/wmcr_mask_reg.sv
module wmcr_mask_reg #(
   parameter int unsigned         DATA_W    = 64,
   parameter logic [DATA_W-1:0]   RSVD_BITS = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] mask_q,
   output logic              live
);

   localparam logic [DATA_W-1:0] KEEP = ~RSVD_BITS;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (we) begin
         mask_q <= wdata & KEEP;
      end
   end

   assign live = |mask_q;

   // R6: the mask only moves on an accepted write
   p_mask_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(mask_q));

endmodule

// File: rtl/wmcr_ctrl_reg.sv
module wmcr_ctrl_reg #(
   parameter int unsigned         DATA_W    = 64,
   parameter logic [DATA_W-1:0]   RSVD_BITS = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] mask,
   output logic [DATA_W-1:0] ctrl_q
);

   localparam logic [DATA_W-1:0] KEEP = ~RSVD_BITS;

   logic [DATA_W-1:0] ctrl_d;

   always_comb begin
      ctrl_d = ((ctrl_q & mask) | (wdata & ~mask)) & KEEP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (we) begin
         ctrl_q <= ctrl_d;
      end
   end

   // R3: bits under the mask survive a write
   p_masked_keep_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ((ctrl_q & $past(mask)) == ($past(ctrl_q) & $past(mask))));

   // R2: open, non-reserved bits take the written data
   p_open_take_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ((ctrl_q & ~$past(mask) & KEEP) == ($past(wdata) & ~$past(mask) & KEEP)));

   // R10: no write, no change
   p_ctrl_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(ctrl_q));

endmodule

// File: rtl/wmcr_top.sv
module wmcr_top
   import wmcr_pkg::*;
#(
   parameter int unsigned       DATA_W    = 64,
   parameter logic [DATA_W-1:0] RSVD_BITS = 64'h0000_0280_0002_0000,
   parameter bit                ALIAS_EN  = 1'b1,
   parameter logic [1:0]        LOCK_PRV  = 2'd1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_target,
   input  logic [1:0]        req_priv,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              err_o,
   output logic [DATA_W-1:0] ctrl_q_o,
   output logic [DATA_W-1:0] mask_q_o
);

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("wmcr_top: DATA_W must be at least 8");
      end
      if (LOCK_PRV == 2'd0) begin : g_bad_lock
         $error("wmcr_top: LOCK_PRV cannot be the user level");
      end
   endgenerate

   dec_t              dec;
   logic              mask_live;
   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] ctrl_q;

   wmcr_access_check #(
      .ALIAS_EN (ALIAS_EN),
      .LOCK_PRV (LOCK_PRV)
   ) u_check (
      .valid     (req_valid),
      .write     (req_write),
      .tgt       (req_target),
      .prv       (req_priv),
      .mask_live (mask_live),
      .dec       (dec)
   );

   wmcr_mask_reg #(
      .DATA_W    (DATA_W),
      .RSVD_BITS (RSVD_BITS)
   ) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (dec.mask_we),
      .wdata  (req_wdata),
      .mask_q (mask_q),
      .live   (mask_live)
   );

   wmcr_ctrl_reg #(
      .DATA_W    (DATA_W),
      .RSVD_BITS (RSVD_BITS)
   ) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (dec.ctrl_we),
      .wdata  (req_wdata),
      .mask   (mask_q),
      .ctrl_q (ctrl_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data_o <= '0;
         err_o     <= 1'b0;
      end else begin
         err_o <= dec.reject;
         if (dec.rd_en) begin
            rd_data_o <= dec.rd_mask ? mask_q : ctrl_q;
         end
      end
   end

   assign ctrl_q_o = ctrl_q;
   assign mask_q_o = mask_q;

   // R9: user level is always refused
   p_user_err_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_priv == 2'd0)) |=> err_o);

   // R6: a live mask refuses a kernel rewrite
   p_lock_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && (req_target == 2'd2) && (req_priv == LOCK_PRV)
       && (mask_q_o != '0)) |=> (err_o && $stable(mask_q_o)));

   // R8: elevated levels always rewrite the mask
   p_top_write_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && (req_target == 2'd2) && (req_priv >= 2'd2))
      |=> (!err_o && (mask_q_o == ($past(req_wdata) & ~RSVD_BITS))));

   // R10: an error leaves both registers untouched and follows a request
   p_err_quiet_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> ($stable(ctrl_q_o) && $stable(mask_q_o) && $past(req_valid)));

   // R11: control read returns the value held at request time
   p_read_ctrl_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && (req_target == 2'd0) && (req_priv != 2'd0))
      |=> (rd_data_o == $past(ctrl_q_o)));

endmodule

// File: tb/wmcr_top_tb_top.sv
`timescale 1ns/1ps
module wmcr_top_tb_top;

   localparam logic [63:0] RSVD = 64'h0000_0280_0002_0000;

   typedef struct packed {
      logic        wr;
      logic [1:0]  tgt;
      logic [1:0]  prv;
      logic [63:0] wd;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 2'd0, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF},
      '{1'b0, 2'd0, 2'd1, 64'h0},
      '{1'b1, 2'd2, 2'd3, 64'h0000_0000_FFFF_0000},
      '{1'b1, 2'd0, 2'd1, 64'h0},
      '{1'b1, 2'd1, 2'd1, 64'h5555_5555_5555_5555},
      '{1'b1, 2'd2, 2'd1, 64'h0000_0000_0000_0001},
      '{1'b0, 2'd2, 2'd2, 64'h0},
      '{1'b1, 2'd2, 2'd3, 64'h0},
      '{1'b1, 2'd2, 2'd1, 64'hF0F0_F0F0_0F0F_0F0F},
      '{1'b1, 2'd1, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF},
      '{1'b1, 2'd0, 2'd0, 64'h1234_5678_9ABC_DEF0},
      '{1'b0, 2'd2, 2'd0, 64'h0},
      '{1'b1, 2'd3, 2'd3, 64'hDEAD_BEEF_DEAD_BEEF},
      '{1'b1, 2'd2, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF},
      '{1'b1, 2'd0, 2'd3, 64'h0},
      '{1'b0, 2'd1, 2'd3, 64'h0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [1:0]  req_target = 2'd0;
   logic [1:0]  req_priv = 2'd0;
   logic [63:0] req_wdata = '0;
   logic [63:0] rd_data_o;
   logic        err_o;
   logic [63:0] ctrl_q_o;
   logic [63:0] mask_q_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [63:0] m_ctrl = '0;
   logic [63:0] m_mask = '0;
   logic [63:0] m_rd   = '0;

   always #4 clk = ~clk;

   wmcr_top dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_target (req_target),
      .req_priv   (req_priv),
      .req_wdata  (req_wdata),
      .rd_data_o  (rd_data_o),
      .err_o      (err_o),
      .ctrl_q_o   (ctrl_q_o),
      .mask_q_o   (mask_q_o)
   );

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic string tag_of(input logic wr, input logic [1:0] tgt,
                                    input logic [1:0] prv);
      if (prv == 2'd0) return "R9";
      if (tgt == 2'd3) return "R10";
      if (!wr)         return "R11";
      if (tgt == 2'd2) begin
         if (prv == 2'd1) return (m_mask != '0) ? "R6" : "R7";
         return "R8";
      end
      if (tgt == 2'd1) return "R4";
      return (m_mask != '0) ? "R3" : "R2";
   endfunction

   task automatic step(input vec_t v);
      string tag;
      logic  exp_err;
      tag = tag_of(v.wr, v.tgt, v.prv);
      exp_err = (v.prv == 2'd0) || (v.tgt == 2'd3) ||
                (v.wr && (v.tgt == 2'd2) && (v.prv == 2'd1) && (m_mask != '0));
      if (!exp_err) begin
         if (v.wr && (v.tgt == 2'd2)) m_mask = v.wd & ~RSVD;
         else if (v.wr)               m_ctrl = ((m_ctrl & m_mask) | (v.wd & ~m_mask)) & ~RSVD;
         else                         m_rd   = (v.tgt == 2'd2) ? m_mask : m_ctrl;
      end
      req_valid  = 1'b1;
      req_write  = v.wr;
      req_target = v.tgt;
      req_priv   = v.prv;
      req_wdata  = v.wd;
      @(negedge clk);
      req_valid  = 1'b0;
      chk(tag, "err",   {63'd0, err_o}, {63'd0, exp_err});
      chk(tag, "ctrl",  ctrl_q_o, m_ctrl);
      chk(tag, "mask",  mask_q_o, m_mask);
      chk(tag, "rdata", rd_data_o, m_rd);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "ctrl",  ctrl_q_o, '0);
      chk("R1", "mask",  mask_q_o, '0);
      chk("R1", "rdata", rd_data_o, '0);
      chk("R1", "err",   {63'd0, err_o}, '0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         step(VECS[i]);
      end

      // R10: error pulse lasts one cycle
      step('{1'b0, 2'd3, 2'd1, 64'h0});
      @(negedge clk);
      chk("R10", "err after idle", {63'd0, err_o}, '0);

      // R5: all-ones into both registers leaves reserved bits clear
      step('{1'b1, 2'd2, 2'd3, 64'h0});
      step('{1'b1, 2'd0, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF});
      step('{1'b1, 2'd2, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF});
      chk("R5", "ctrl reserved", ctrl_q_o & RSVD, '0);
      chk("R5", "mask reserved", mask_q_o & RSVD, '0);

      // R6: fully locked mask still refuses kernel, R4 alias write changes nothing
      step('{1'b1, 2'd2, 2'd1, 64'h0});
      step('{1'b1, 2'd1, 2'd1, 64'h0});

      // R1: reset in mid-run clears everything
      rst_n = 1'b0;
      #1;
      chk("R1", "ctrl mid reset",  ctrl_q_o, '0);
      chk("R1", "mask mid reset",  mask_q_o, '0);
      chk("R1", "rdata mid reset", rd_data_o, '0);
      m_ctrl = '0; m_mask = '0; m_rd = '0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      step('{1'b1, 2'd2, 2'd1, 64'h0000_0000_0000_00F0});

      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule